// File: doc/BRIEF.md
# Memory Client Hot-Reset Flush Engine

This engine drains the memory-controller clients that belong to a power partition before that partition loses power. Every partition owns a short list of at most three client numbers. On a flush command the engine walks this list strictly in order. For the current client it raises one bit in the hot-reset request vector. It then checks the matching acknowledge bit in the status vector once per poll interval, and it moves to the next client only after that bit reads 1. When the last listed client has acknowledged, the engine emits a one-cycle flush-complete pulse. The request bits stay high, which holds the clients quiet while the partition is off.

A release command drops the request bits of every client listed for the selected partition in a single step. It does not look at the status vector. Request bits raised for other partitions are left alone, both by flush and by release. A partition with an empty list, or an index past the last partition, completes at once and leaves the request vector unchanged.

Top module: `hrf_flush_engine`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `hr_ctrl` is all zeros and neither done output is high.
- R2: A flush raises the request bits of its partition's clients one at a time, in list order. The next bit rises only after the previous client's `hr_status` bit has been sampled as 1. No cycle raises more than one new bit.
- R3: The first status sample for a client happens POLL_INTERVAL cycles after its request bit rises. A sample that reads 0 is retried every POLL_INTERVAL cycles. Between samples the request vector and `flush_done` do not change.
- R4: Setting a bit is a read-modify-write. Request bits already high, for example those left by an earlier flush of another partition, stay high.
- R5: `flush_done` is high for exactly one cycle. That cycle follows the clock edge at which the last client's acknowledge was sampled. The request bits stay high after it.
- R6: A flush of a partition with no clients (partitions 0 and 1) pulses `flush_done` in the cycle after the start and changes nothing.
- R7: A flush or release for an index of NUM_PARTS or more pulses its done output in the cycle after the start and changes nothing.
- R8: A release clears only the request bits of the selected partition's clients. It pulses `release_done` in the cycle after the start and ignores `hr_status`. `hr_ctrl` bits only ever fall in a `release_done` cycle.
- R9: The client lists are:
  - partition 2 → 12
  - partition 3 → 0
  - partition 4 → 16
  - partition 5 → 11
  - partition 6 → 8 then 17
  - partition 7 → 15
  - partition 8 → 13
  - partition 9 → 5, then 4, then 6

  Client n owns bit n of `hr_ctrl` and of `hr_status`.
- R10: Starts that arrive while a flush is in progress are ignored. If both starts are high in the same idle cycle, the flush is taken and the release is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| part_idx | input | PART_W | Partition index, sampled with a start |
| flush_start | input | 1 | Start a flush of `part_idx` |
| release_start | input | 1 | Start a release of `part_idx` |
| hr_status | input | NUM_CLIENTS | Per-client hot-reset acknowledge |
| hr_ctrl | output | NUM_CLIENTS | Per-client hot-reset request |
| flush_done | output | 1 | One-cycle flush complete pulse |
| release_done | output | 1 | One-cycle release complete pulse |

## Verification
The bench builds the engine with POLL_INTERVAL set to 3 rather than 4. This makes the time until a retried sample short, so a slow client is polled several times within a short run. PART_W stays at 4 with ten partitions, so indices 10 to 15 are available as invalid requests. The acknowledge model gives each client its own latency. This lets the three-client partition stall in the middle of its list while starts are driven against the busy engine, and it lets a release clear bits whose acknowledges are still high.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } hrf_state_e;

    // Client number in a given list slot of a partition, or -1 when the list ends.
    function automatic int hrf_part_client(input int part, input int slot);
        int c0, c1, c2;
        c0 = -1; c1 = -1; c2 = -1;
        case (part)
            2: c0 = 12;
            3: c0 = 0;
            4: c0 = 16;
            5: c0 = 11;
            6: begin c0 = 8; c1 = 17; end
            7: c0 = 15;
            8: c0 = 13;
            9: begin c0 = 5; c1 = 4; c2 = 6; end
            default: c0 = -1;
        endcase
        case (slot)
            0: return c0;
            1: return c1;
            2: return c2;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/hrf_client_map.sv
module hrf_client_map
    import hrf_pkg::*;
#(
    parameter int PART_W    = 4,
    parameter int NUM_PARTS = 10,
    parameter int CLIENT_W  = 5,
    parameter int SLOTS     = 3,
    parameter int CNT_W     = 2
) (
    input  logic [PART_W-1:0]                part,
    output logic                             part_ok,
    output logic [CNT_W-1:0]                 count,
    output logic [SLOTS-1:0][CLIENT_W-1:0]   clients
);

    logic [SLOTS-1:0] present;

    assign part_ok = (int'(part) < NUM_PARTS);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        int raw;
        always_comb begin
            raw        = hrf_part_client(int'(part), s);
            present[s] = part_ok && (raw >= 0);
            clients[s] = present[s] ? CLIENT_W'(raw) : '0;
        end
    end

    // The list length counts the slots before the first terminator.
    always_comb begin
        logic stop;
        stop  = 1'b0;
        count = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (present[s] && !stop) count = count + CNT_W'(1);
            else                     stop  = 1'b1;
        end
    end

endmodule

// File: rtl/hrf_client_mask.sv
module hrf_client_mask #(
    parameter int NUM_CLIENTS = 18,
    parameter int CLIENT_W    = 5,
    parameter int SLOTS       = 3,
    parameter int CNT_W       = 2
) (
    input  logic [SLOTS-1:0][CLIENT_W-1:0] clients,
    input  logic [CNT_W-1:0]               count,
    output logic [NUM_CLIENTS-1:0]         mask
);

    logic [SLOTS-1:0][NUM_CLIENTS-1:0] per_slot;

    for (genvar s = 0; s < SLOTS; s++) begin : g_bit
        assign per_slot[s] = (CNT_W'(s) < count)
                           ? (NUM_CLIENTS'(1) << clients[s]) : '0;
    end

    always_comb begin
        mask = '0;
        for (int s = 0; s < SLOTS; s++) mask = mask | per_slot[s];
    end

endmodule

// File: rtl/hrf_flush_engine.sv
module hrf_flush_engine
    import hrf_pkg::*;
#(
    parameter int NUM_CLIENTS   = 18,
    parameter int NUM_PARTS     = 10,
    parameter int PART_W        = 4,
    parameter int SLOTS         = 3,
    parameter int POLL_INTERVAL = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PART_W-1:0]      part_idx,
    input  logic                   flush_start,
    input  logic                   release_start,
    input  logic [NUM_CLIENTS-1:0] hr_status,
    output logic [NUM_CLIENTS-1:0] hr_ctrl,
    output logic                   flush_done,
    output logic                   release_done
);

    localparam int CLIENT_W = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1;
    localparam int CNT_W    = $clog2(SLOTS + 1);
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int TMR_W    = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL) : 1;
    localparam logic [TMR_W-1:0] TMR_RELOAD = TMR_W'(POLL_INTERVAL - 1);

    typedef struct packed {
        hrf_state_e             st;
        logic [PART_W-1:0]      part;
        logic [SLOT_W-1:0]      slot;
        logic [TMR_W-1:0]       timer;
        logic [NUM_CLIENTS-1:0] ctrl;
        logic                   fdone;
        logic                   rdone;
    } hrf_regs_t;

    hrf_regs_t r_d, r_q;

    logic [PART_W-1:0]                 map_part;
    logic                              map_ok;
    logic [CNT_W-1:0]                  map_count;
    logic [SLOTS-1:0][CLIENT_W-1:0]    map_clients;
    logic [NUM_CLIENTS-1:0]            part_mask;
    logic [CLIENT_W-1:0]               cur_client, nxt_client;
    logic                              nxt_present;

    // In idle the list comes from the input index, during a flush from the latched one.
    assign map_part = (r_q.st == ST_IDLE) ? part_idx : r_q.part;

    hrf_client_map #(
        .PART_W(PART_W), .NUM_PARTS(NUM_PARTS), .CLIENT_W(CLIENT_W),
        .SLOTS(SLOTS), .CNT_W(CNT_W)
    ) map_i (
        .part(map_part), .part_ok(map_ok), .count(map_count), .clients(map_clients)
    );

    hrf_client_mask #(
        .NUM_CLIENTS(NUM_CLIENTS), .CLIENT_W(CLIENT_W), .SLOTS(SLOTS), .CNT_W(CNT_W)
    ) mask_i (
        .clients(map_clients), .count(map_count), .mask(part_mask)
    );

    always_comb begin
        cur_client = '0;
        nxt_client = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (int'(r_q.slot) == i)     cur_client = map_clients[i];
            if (int'(r_q.slot) + 1 == i) nxt_client = map_clients[i];
        end
        nxt_present = (int'(r_q.slot) + 1) < int'(map_count);
    end

    always_comb begin
        r_d       = r_q;
        r_d.fdone = 1'b0;
        r_d.rdone = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (flush_start) begin
                    if (!map_ok || map_count == '0) begin
                        r_d.fdone = 1'b1;
                    end else begin
                        r_d.st    = ST_WAIT;
                        r_d.part  = part_idx;
                        r_d.slot  = '0;
                        r_d.timer = TMR_RELOAD;
                        r_d.ctrl  = r_q.ctrl | (NUM_CLIENTS'(1) << map_clients[0]);
                    end
                end else if (release_start) begin
                    r_d.rdone = 1'b1;
                    if (map_ok) r_d.ctrl = r_q.ctrl & ~part_mask;
                end
            end
            ST_WAIT: begin
                if (r_q.timer != '0) begin
                    r_d.timer = r_q.timer - TMR_W'(1);
                end else if (hr_status[cur_client]) begin
                    if (nxt_present) begin
                        r_d.slot  = r_q.slot + SLOT_W'(1);
                        r_d.timer = TMR_RELOAD;
                        r_d.ctrl  = r_q.ctrl | (NUM_CLIENTS'(1) << nxt_client);
                    end else begin
                        r_d.st    = ST_IDLE;
                        r_d.fdone = 1'b1;
                    end
                end else begin
                    r_d.timer = TMR_RELOAD;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hr_ctrl      = r_q.ctrl;
    assign flush_done   = r_q.fdone;
    assign release_done = r_q.rdone;

    logic waiting, timer_idle;
    assign waiting    = (r_q.st == ST_WAIT);
    assign timer_idle = (r_q.timer == '0);

endmodule

// File: rtl/hrf_flush_engine_chk.sv
module hrf_flush_engine_chk #(
    parameter int NUM_CLIENTS = 18
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CLIENTS-1:0] hr_ctrl,
    input logic                   flush_done,
    input logic                   release_done,
    input logic                   waiting,
    input logic                   timer_idle
);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (hr_ctrl == '0 && !flush_done && !release_done));

    p_one_new_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hr_ctrl & ~$past(hr_ctrl)) <= 1);

    p_quiet_between_polls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !timer_idle) |=> ($stable(hr_ctrl) && !flush_done));

    p_done_ends_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !waiting);

    p_clear_only_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(hr_ctrl) & ~hr_ctrl)) |-> release_done);

    p_release_sets_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_done |-> ((hr_ctrl & ~$past(hr_ctrl)) == '0));

    p_single_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_done && release_done));

endmodule

bind hrf_flush_engine hrf_flush_engine_chk #(.NUM_CLIENTS(NUM_CLIENTS)) chk_i (
    .clk(clk), .rst_n(rst_n), .hr_ctrl(hr_ctrl), .flush_done(flush_done),
    .release_done(release_done), .waiting(waiting), .timer_idle(timer_idle)
);

// File: tb/hrf_flush_engine_tb_top.sv
`timescale 1ns/1ps
module hrf_flush_engine_tb_top;

    localparam int NC   = 18;
    localparam int NP   = 10;
    localparam int PW   = 4;
    localparam int POLL = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] part_idx = '0;
    logic          flush_start = 1'b0;
    logic          release_start = 1'b0;
    logic [NC-1:0] hr_status = '0;
    logic [NC-1:0] hr_ctrl;
    logic          flush_done, release_done;

    always #4 clk = ~clk;

    hrf_flush_engine #(
        .NUM_CLIENTS(NC), .NUM_PARTS(NP), .PART_W(PW), .SLOTS(3), .POLL_INTERVAL(POLL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .part_idx(part_idx), .flush_start(flush_start),
        .release_start(release_start), .hr_status(hr_status), .hr_ctrl(hr_ctrl),
        .flush_done(flush_done), .release_done(release_done)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // Expected client lists, written from the requirement text.
    function automatic int ref_client(int p, int s);
        int l[$];
        case (p)
            2: l = '{12};
            3: l = '{0};
            4: l = '{16};
            5: l = '{11};
            6: l = '{8, 17};
            7: l = '{15};
            8: l = '{13};
            9: l = '{5, 4, 6};
            default: l = '{};
        endcase
        if (s < l.size()) return l[s];
        return -1;
    endfunction

    function automatic int ref_len(int p);
        int n = 0;
        while (n < 3 && ref_client(p, n) >= 0) n++;
        return n;
    endfunction

    // Acknowledge model: status follows a request after a per-client latency.
    int lat [NC];
    int held[NC];
    initial for (int c = 0; c < NC; c++) begin lat[c] = 2; held[c] = 0; end

    always @(negedge clk) begin
        for (int c = 0; c < NC; c++) begin
            if (hr_ctrl[c]) held[c] = (held[c] < 1000) ? held[c] + 1 : held[c];
            else            held[c] = 0;
            hr_status[c] <= hr_ctrl[c] && (held[c] >= lat[c]);
        end
    end

    // Behavioural reference, advanced on every rising edge.
    bit          m_busy = 0;
    int          m_part = 0, m_slot = 0, m_wait = 0;
    logic [NC-1:0] m_ctrl = '0;
    bit          m_fd = 0, m_rd = 0;

    always @(posedge clk) begin
        bit nf, nr;
        nf = 0; nr = 0;
        if (!rst_n) begin
            m_busy = 0; m_ctrl = '0; m_slot = 0; m_wait = 0; m_part = 0;
        end else if (!m_busy) begin
            if (flush_start) begin
                if (ref_len(int'(part_idx)) == 0) nf = 1;
                else begin
                    m_busy = 1; m_part = int'(part_idx); m_slot = 0; m_wait = POLL - 1;
                    m_ctrl[ref_client(m_part, 0)] = 1'b1;
                end
            end else if (release_start) begin
                nr = 1;
                for (int s = 0; s < ref_len(int'(part_idx)); s++)
                    m_ctrl[ref_client(int'(part_idx), s)] = 1'b0;
            end
        end else begin
            if (m_wait > 0) m_wait--;
            else if (hr_status[ref_client(m_part, m_slot)]) begin
                if (m_slot + 1 < ref_len(m_part)) begin
                    m_slot++; m_wait = POLL - 1;
                    m_ctrl[ref_client(m_part, m_slot)] = 1'b1;
                end else begin
                    nf = 1; m_busy = 0;
                end
            end else m_wait = POLL - 1;
        end
        m_fd = nf; m_rd = nr;
    end

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_vec++;
            if (hr_ctrl !== m_ctrl || flush_done !== m_fd || release_done !== m_rd) begin
                n_bad++;
                $display("FAIL %s: ctrl=%h fd=%b rd=%b expected ctrl=%h fd=%b rd=%b",
                         cur_req, hr_ctrl, flush_done, release_done, m_ctrl, m_fd, m_rd);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start(input int p, input bit f, input bit r);
        @(negedge clk);
        part_idx = PW'(p); flush_start = f; release_start = r;
        @(negedge clk);
        flush_start = 0; release_start = 0;
    endtask

    task automatic wait_flush();
        for (int i = 0; i < 400; i++) begin
            if (flush_done) return;
            @(negedge clk);
        end
        n_bad++;
        $display("FAIL %s: flush_done never seen", cur_req);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R1";
        check("R1", {hr_ctrl, flush_done, release_done}, '0);
        rst_n = 1;
        @(negedge clk);
        check("R1", {hr_ctrl, flush_done, release_done}, '0);

        // R9/R2: two-client partition, list order 8 then 17.
        cur_req = "R9";
        start(6, 1, 0);
        check("R2", hr_ctrl, 32'(18'h00100));
        wait_flush();
        check("R5", hr_ctrl, 32'(18'h20100));
        @(negedge clk);
        check("R5", flush_done, 0);

        // R3/R4: three-client partition with a slow middle client.
        cur_req = "R3";
        lat[4] = 11;
        start(9, 1, 0);
        check("R4", hr_ctrl, 32'(18'h20120));
        repeat (6) @(negedge clk);
        // R10: starts while busy must be ignored.
        cur_req = "R10";
        start(6, 0, 1);
        check("R10", {release_done, hr_ctrl[17], hr_ctrl[8]}, 32'h3);
        start(2, 1, 0);
        check("R10", hr_ctrl[12], 0);
        cur_req = "R3";
        wait_flush();
        check("R4", hr_ctrl, 32'(18'h20170));
        lat[4] = 2;

        // R8: release of partition 6 leaves partition 9's bits.
        cur_req = "R8";
        start(6, 0, 1);
        check("R8", {release_done, hr_ctrl}, {1'b1, 18'h00070});

        // R6: empty partitions.
        cur_req = "R6";
        start(0, 1, 0);
        check("R6", {flush_done, hr_ctrl}, {1'b1, 18'h00070});
        start(1, 1, 0);
        check("R6", {flush_done, hr_ctrl}, {1'b1, 18'h00070});

        // R7: invalid indices.
        cur_req = "R7";
        start(12, 1, 0);
        check("R7", {flush_done, hr_ctrl}, {1'b1, 18'h00070});
        start(15, 0, 1);
        check("R7", {release_done, hr_ctrl}, {1'b1, 18'h00070});

        // R10: simultaneous starts in idle, flush wins.
        cur_req = "R10";
        start(3, 1, 1);
        check("R10", {release_done, hr_ctrl}, {1'b0, 18'h00071});
        wait_flush();
        cur_req = "R8";
        start(9, 0, 1);
        check("R8", hr_ctrl, 32'(18'h00001));
        start(3, 0, 1);
        check("R8", hr_ctrl, 0);

        // R9: every partition in turn, then release each.
        cur_req = "R9";
        for (int p = 2; p < NP; p++) begin
            start(p, 1, 0);
            wait_flush();
        end
        check("R9", hr_ctrl, 32'(18'h3B971));
        for (int p = 0; p < NP; p++) start(p, 0, 1);
        check("R8", hr_ctrl, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule